// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block drives complete SMBus host-side transactions through a byte-level I2C engine. The engine carries out one bus primitive per request: start, repeated start, stop, a byte write that reports whether the target acknowledged, or a byte read with an acknowledge bit chosen by the sequencer. For each transaction shape the sequencer picks the order of these primitives, inserts the command and count bytes, sets the acknowledge on every read, and ends the transfer early if something goes wrong.

A command is accepted when `cmd_valid` is high and the block is idle. Block payloads are loaded into a small write buffer before the command is issued. Received bytes go into a read buffer, which can be read back after `rsp_done`. Word results and the received byte count are also shown directly on the response port. Bit timing, clock-stretch timeouts, packet error checking and arbitration belong to the engine or to other blocks.

Top module: `smb_txn_seq`

## Requirements
- R1: `cmd_kind` codes are 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read, 10 block process call, 11 raw block write (no count), 12 raw block read (no count). A kind above 12, or a buffer-using kind (8, 10, 11, 12) with `cmd_len` equal to 0 or above 32, is answered with `rsp_done` and `rsp_err` and no engine request.
- R2: Engine operations are coded 0 start, 1 repeated start, 2 stop, 3 byte write, 4 byte read. `eng_req` is a one-cycle pulse, and no new request is made before `eng_done` answers the previous one.
- R3: Quick command issues start, a write of {address, `cmd_qbit`}, then stop, with no data phase.
- R4: Send byte issues start, {address,0}, `cmd_word[7:0]`, stop. Receive byte issues start, {address,1}, one read with NACK (`eng_ack`=0), stop, and returns the byte in `rsp_word[7:0]`. Neither sends a command byte.
- R5: Write byte and write word issue start, {address,0}, `cmd_code`, the data (a word goes low byte then high byte), stop.
- R6: Read byte and read word issue start, {address,0}, `cmd_code`, repeated start, {address,1}, then the reads. Every read except the last is ACKed (`eng_ack`=1). The last read is NACKed and followed directly by stop. A word is returned low byte first into `rsp_word`.
- R7: Process call writes `cmd_code` and `cmd_word` (low byte first), then issues a repeated start and {address,1}, and reads back a word into `rsp_word`.
- R8: Block write sends `cmd_len` as a count byte after `cmd_code`, then write-buffer entries 0..len-1. The raw variant omits the count byte.
- R9: Block read ACKs the received count byte, then reads exactly that many bytes into read-buffer entries 0..n-1 and reports n on `rsp_count`. The raw variant reads `cmd_len` bytes with no count byte.
- R10: In a block read, a received count of 0 or above 32 sets `rsp_err`. The sequencer then performs one NACKed read and a stop.
- R11: Block process call writes a count and the data, then after the repeated start reads a count. A count above 32 is clamped to 32, and exactly that many bytes are read. A count of 0 is an error handled as in R10.
- R12: A write byte that is not acknowledged (`eng_nack`) causes an immediate stop and sets `rsp_err`. No further byte is written.
- R13: After reset `busy`, `rsp_done` and `eng_req` are low. `busy` stays high from acceptance until `rsp_done`, which is a one-cycle pulse issued after the final stop completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a transaction (taken when idle) |
| cmd_kind | input | 4 | Transaction kind code (R1) |
| cmd_addr | input | 7 | Target 7-bit address |
| cmd_qbit | input | 1 | Payload bit for quick command |
| cmd_code | input | 8 | Command byte |
| cmd_word | input | 16 | Byte or word write data |
| cmd_len | input | CW | Block length for buffer-using kinds |
| busy | output | 1 | Transaction in progress |
| wbuf_we | input | 1 | Write-buffer write enable |
| wbuf_addr | input | AW | Write-buffer index |
| wbuf_data | input | 8 | Write-buffer data |
| eng_req | output | 1 | Engine operation request pulse |
| eng_op | output | 3 | Engine operation code (R2) |
| eng_wdata | output | 8 | Byte to write |
| eng_ack | output | 1 | Acknowledge to send after a read |
| eng_done | input | 1 | Engine operation finished |
| eng_nack | input | 1 | Written byte was not acknowledged |
| eng_rdata | input | 8 | Byte read by the engine |
| rsp_done | output | 1 | Transaction finished pulse |
| rsp_err | output | 1 | Transaction failed |
| rsp_word | output | 16 | Byte or word read result |
| rsp_count | output | CW | Number of bytes received |
| rbuf_addr | input | AW | Read-buffer index |
| rbuf_data | output | 8 | Read-buffer data, one cycle after address |

## Verification
The bench records every engine request and compares the whole primitive stream against the expected one for each kind. A design that misplaced the repeated start, sent a command byte for send or receive byte, or ACKed the last read would show up as a wrong entry. Block reads are driven with counts of 0 and 40, and the block process call with 40. This separates reject from clamp: a design that clamped in block read, or rejected in process call, would report the wrong error flag and the wrong number of reads. A NACK on the command byte and one on the address check that the next primitive is stop. A zero length checks that nothing reaches the engine.

// File: rtl/smb_seq_pkg.sv
`timescale 1ns/1ps
package smb_seq_pkg;
  typedef enum logic [3:0] {
    K_QUICK = 4'd0, K_SEND = 4'd1, K_RECV = 4'd2, K_WRBYTE = 4'd3,
    K_RDBYTE = 4'd4, K_WRWORD = 4'd5, K_RDWORD = 4'd6, K_PCALL = 4'd7,
    K_BLKWR = 4'd8, K_BLKRD = 4'd9, K_BLKPCALL = 4'd10, K_RAWWR = 4'd11,
    K_RAWRD = 4'd12
  } kind_e;

  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_RSTART = 3'd1, OP_STOP = 3'd2, OP_WRITE = 3'd3, OP_READ = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_ADDR1, PH_CODE, PH_WCNT, PH_WDATA, PH_RSTART,
    PH_ADDR2, PH_RCNT, PH_RDATA, PH_RDUMP, PH_STOP, PH_FIN
  } phase_e;

  function automatic logic k_writes(kind_e k);
    return k inside {K_SEND, K_WRBYTE, K_WRWORD, K_PCALL, K_BLKWR, K_BLKPCALL, K_RAWWR};
  endfunction
  function automatic logic k_reads(kind_e k);
    return k inside {K_RECV, K_RDBYTE, K_RDWORD, K_PCALL, K_BLKRD, K_BLKPCALL, K_RAWRD};
  endfunction
  function automatic logic k_wcount(kind_e k);
    return k inside {K_BLKWR, K_BLKPCALL};
  endfunction
  function automatic logic k_rcount(kind_e k);
    return k inside {K_BLKRD, K_BLKPCALL};
  endfunction
  function automatic logic k_fromram(kind_e k);
    return k inside {K_BLKWR, K_BLKPCALL, K_RAWWR};
  endfunction
  function automatic logic k_uselen(kind_e k);
    return k_fromram(k) || (k == K_RAWRD);
  endfunction
  function automatic logic k_word(kind_e k);
    return k inside {K_WRWORD, K_RDWORD, K_PCALL};
  endfunction
endpackage

// File: rtl/smb_seq_ram.sv
`timescale 1ns/1ps
module smb_seq_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smb_txn_seq.sv
`timescale 1ns/1ps
module smb_txn_seq
  import smb_seq_pkg::*;
#(
  parameter int MAX_BLK = 32,
  parameter int CW      = $clog2(MAX_BLK + 1),
  parameter int AW      = $clog2(MAX_BLK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_kind,
  input  logic [6:0]    cmd_addr,
  input  logic          cmd_qbit,
  input  logic [7:0]    cmd_code,
  input  logic [15:0]   cmd_word,
  input  logic [CW-1:0] cmd_len,
  output logic          busy,
  input  logic          wbuf_we,
  input  logic [AW-1:0] wbuf_addr,
  input  logic [7:0]    wbuf_data,
  output logic          eng_req,
  output logic [2:0]    eng_op,
  output logic [7:0]    eng_wdata,
  output logic          eng_ack,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [15:0]   rsp_word,
  output logic [CW-1:0] rsp_count,
  input  logic [AW-1:0] rbuf_addr,
  output logic [7:0]    rbuf_data
);
  localparam logic [7:0]    MAXB8  = 8'(MAX_BLK);
  localparam logic [CW-1:0] MAXBC  = CW'(MAX_BLK);
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [3:0]    KLAST  = 4'(K_RAWRD);

  phase_e        ph;
  kind_e         kind_q, ck;
  logic [6:0]    addr_q;
  logic          qbit_q;
  logic [7:0]    code_q;
  logic [15:0]   word_q;
  logic [CW-1:0] len_q, nwr_q, nrd_q, idx_q, rcv_q;
  logic          pend, gap, err_q, rdnack_q, wnack_q;
  logic [7:0]    wb_q;
  logic          wr_last, rd_last, active, issue, reject, opdone, rb_we;
  op_e           iss_op;
  logic [7:0]    iss_dat;
  logic          iss_ack;

  assign ck      = kind_e'(cmd_kind);
  assign reject  = (cmd_kind > KLAST) || (k_uselen(ck) && (cmd_len == '0 || cmd_len > MAXBC));
  assign wr_last = (idx_q + ONE) == nwr_q;
  assign rd_last = (idx_q + ONE) == nrd_q;
  assign active  = !(ph inside {PH_IDLE, PH_FIN});
  assign issue   = active && !pend && !gap;
  assign opdone  = eng_done && pend;
  assign rb_we   = opdone && (ph == PH_RDATA);
  assign busy    = (ph != PH_IDLE);
  assign rsp_count = rcv_q;

  smb_seq_ram #(.DW(8), .DEPTH(MAX_BLK), .AW(AW)) u_wbuf (
    .clk(clk), .we(wbuf_we), .waddr(wbuf_addr), .wdata(wbuf_data),
    .raddr(idx_q[AW-1:0]), .rdata(wb_q));

  smb_seq_ram #(.DW(8), .DEPTH(MAX_BLK), .AW(AW)) u_rbuf (
    .clk(clk), .we(rb_we), .waddr(idx_q[AW-1:0]), .wdata(eng_rdata),
    .raddr(rbuf_addr), .rdata(rbuf_data));

  // Primitive chosen for the current phase.
  always_comb begin
    iss_op  = OP_WRITE;
    iss_dat = 8'h00;
    iss_ack = 1'b0;
    unique case (ph)
      PH_START:  iss_op = OP_START;
      PH_ADDR1:  iss_dat = {addr_q, (kind_q == K_QUICK) ? qbit_q : (kind_q == K_RECV)};
      PH_CODE:   iss_dat = code_q;
      PH_WCNT:   iss_dat = 8'(len_q);
      PH_WDATA:  iss_dat = k_fromram(kind_q) ? wb_q : (idx_q[0] ? word_q[15:8] : word_q[7:0]);
      PH_RSTART: iss_op = OP_RSTART;
      PH_ADDR2:  iss_dat = {addr_q, 1'b1};
      PH_RCNT:   begin iss_op = OP_READ; iss_ack = 1'b1; end
      PH_RDATA:  begin iss_op = OP_READ; iss_ack = !rd_last; end
      PH_RDUMP:  iss_op = OP_READ;
      PH_STOP:   iss_op = OP_STOP;
      default:   iss_op = OP_WRITE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; pend <= 1'b0; gap <= 1'b0; err_q <= 1'b0;
      eng_req <= 1'b0; eng_op <= 3'd0; eng_wdata <= 8'h00; eng_ack <= 1'b0;
      rsp_done <= 1'b0; rsp_err <= 1'b0; rsp_word <= '0; rcv_q <= '0;
      idx_q <= '0; nwr_q <= '0; nrd_q <= '0; len_q <= '0;
      rdnack_q <= 1'b0; wnack_q <= 1'b0;
      kind_q <= K_QUICK; addr_q <= '0; qbit_q <= 1'b0; code_q <= '0; word_q <= '0;
    end else begin
      eng_req  <= 1'b0;
      rsp_done <= 1'b0;
      gap      <= 1'b0;
      if (issue) begin
        eng_req <= 1'b1; eng_op <= iss_op; eng_wdata <= iss_dat; eng_ack <= iss_ack;
        pend <= 1'b1;
      end
      case (ph)
        PH_IDLE: if (cmd_valid) begin
          kind_q <= ck; addr_q <= cmd_addr; qbit_q <= cmd_qbit; code_q <= cmd_code;
          word_q <= cmd_word; len_q <= cmd_len;
          nwr_q <= k_fromram(ck) ? cmd_len : (k_word(ck) ? CW'(2) : ONE);
          nrd_q <= (ck == K_RAWRD) ? cmd_len : (k_word(ck) ? CW'(2) : ONE);
          err_q <= reject; idx_q <= '0; rcv_q <= '0; rsp_word <= '0;
          rdnack_q <= 1'b0; wnack_q <= 1'b0; gap <= 1'b1;
          ph <= reject ? PH_FIN : PH_START;
        end
        PH_FIN: begin
          rsp_done <= 1'b1; rsp_err <= err_q; ph <= PH_IDLE;
        end
        default: if (opdone) begin
          pend <= 1'b0;
          gap  <= 1'b1;
          if (eng_op == OP_READ && !eng_ack) rdnack_q <= 1'b1;
          if (eng_op == OP_WRITE && eng_nack) begin
            err_q <= 1'b1; wnack_q <= 1'b1; ph <= PH_STOP;
          end else begin
            case (ph)
              PH_START: ph <= PH_ADDR1;
              PH_ADDR1: ph <= (kind_q == K_QUICK) ? PH_STOP :
                              (kind_q == K_RECV)  ? PH_RDATA :
                              (kind_q == K_SEND)  ? PH_WDATA : PH_CODE;
              PH_CODE:  ph <= !k_writes(kind_q) ? PH_RSTART :
                              (k_wcount(kind_q) ? PH_WCNT : PH_WDATA);
              PH_WCNT:  ph <= PH_WDATA;
              PH_WDATA: if (wr_last) begin
                idx_q <= '0;
                ph    <= k_reads(kind_q) ? PH_RSTART : PH_STOP;
              end else idx_q <= idx_q + ONE;
              PH_RSTART: ph <= PH_ADDR2;
              PH_ADDR2:  ph <= k_rcount(kind_q) ? PH_RCNT : PH_RDATA;
              PH_RCNT: if (eng_rdata == 8'h00 || (kind_q == K_BLKRD && eng_rdata > MAXB8)) begin
                err_q <= 1'b1; ph <= PH_RDUMP;
              end else begin
                nrd_q <= (eng_rdata > MAXB8) ? MAXBC : CW'(eng_rdata);
                ph    <= PH_RDATA;
              end
              PH_RDATA: begin
                rcv_q <= rcv_q + ONE;
                if (idx_q == '0) rsp_word[7:0]  <= eng_rdata;
                if (idx_q == ONE) rsp_word[15:8] <= eng_rdata;
                if (rd_last) ph <= PH_STOP;
                else idx_q <= idx_q + ONE;
              end
              PH_RDUMP: ph <= PH_STOP;
              PH_STOP:  ph <= PH_FIN;
              default:  ph <= PH_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst) eng_req |=> !eng_req); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !eng_req); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R13
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst) rsp_count <= MAXBC); // R11
  AST_NACKREAD_STOP: assert property (@(posedge clk) disable iff (rst)
    (eng_req && rdnack_q) |-> (eng_op == 3'(OP_STOP))); // R6
  AST_WNACK_STOP: assert property (@(posedge clk) disable iff (rst)
    (eng_req && wnack_q) |-> (eng_op == 3'(OP_STOP))); // R12
endmodule

// File: tb/smb_txn_seq_tb_top.sv
`timescale 1ns/1ps
module smb_txn_seq_tb_top;
  localparam int CW = 6;
  localparam int AW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_qbit = 1'b0;
  logic [3:0] cmd_kind = '0;
  logic [6:0] cmd_addr = 7'h2A;
  logic [7:0] cmd_code = '0;
  logic [15:0] cmd_word = '0;
  logic [CW-1:0] cmd_len = '0;
  logic busy;
  logic wbuf_we = 1'b0;
  logic [AW-1:0] wbuf_addr = '0;
  logic [7:0] wbuf_data = '0;
  logic eng_req, eng_ack;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata;
  logic eng_done = 1'b0, eng_nack = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic rsp_done, rsp_err;
  logic [15:0] rsp_word;
  logic [CW-1:0] rsp_count;
  logic [AW-1:0] rbuf_addr = '0;
  logic [7:0] rbuf_data;

  always #2 clk = ~clk;

  smb_txn_seq dut_i (
    .clk, .rst, .cmd_valid, .cmd_kind, .cmd_addr, .cmd_qbit, .cmd_code, .cmd_word,
    .cmd_len, .busy, .wbuf_we, .wbuf_addr, .wbuf_data, .eng_req, .eng_op, .eng_wdata,
    .eng_ack, .eng_done, .eng_nack, .eng_rdata, .rsp_done, .rsp_err, .rsp_word,
    .rsp_count, .rbuf_addr, .rbuf_data);

  // Engine / target model: answers each request two cycles later, logs it.
  logic clr = 1'b0, wt = 1'b0, prev_req = 1'b0;
  logic [2:0] mop = '0;
  logic [11:0] log_m [0:127];
  logic [11:0] exp_m [0:127];
  logic [7:0] rd_src [0:63];
  int nlog = 0, rd_i = 0, wr_n = 0, dbl_req = 0;
  int nack_at = -1, nexp = 0, vec = 0, fails = 0;
  bit finished = 0;

  always @(posedge clk) begin
    eng_done <= 1'b0;
    eng_nack <= 1'b0;
    prev_req <= eng_req;
    if (eng_req === 1'b1 && prev_req === 1'b1) dbl_req <= dbl_req + 1;
    if (clr) begin
      nlog <= 0; rd_i <= 0; wr_n <= 0; wt <= 1'b0;
    end else if (eng_req === 1'b1) begin
      log_m[nlog] <= {eng_op, (eng_op == 3'd4) ? eng_ack : 1'b0,
                      (eng_op == 3'd3) ? eng_wdata : 8'h00};
      nlog <= nlog + 1;
      mop  <= eng_op;
      wt   <= 1'b1;
    end else if (wt) begin
      wt <= 1'b0;
      eng_done <= 1'b1;
      if (mop == 3'd4) begin eng_rdata <= rd_src[rd_i[5:0]]; rd_i <= rd_i + 1; end
      if (mop == 3'd3) begin eng_nack <= (wr_n == nack_at); wr_n <= wr_n + 1; end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    vec++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic void ex(logic [2:0] op, logic ack, logic [7:0] d);
    exp_m[nexp] = {op, ack, d};
    nexp++;
  endfunction
  function automatic void ex_w(logic [7:0] d); ex(3'd3, 1'b0, d); endfunction
  function automatic void ex_r(logic a); ex(3'd4, a, 8'h00); endfunction
  function automatic void ex_s(); ex(3'd0, 1'b0, 8'h00); endfunction
  function automatic void ex_rs(); ex(3'd1, 1'b0, 8'h00); endfunction
  function automatic void ex_p(); ex(3'd2, 1'b0, 8'h00); endfunction

  logic r_err;
  logic [15:0] r_word;
  logic [CW-1:0] r_cnt;

  task automatic prep();
    nexp = 0;
    nack_at = -1;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic load_w(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wbuf_we = 1'b1; wbuf_addr = AW'(i); wbuf_data = base + 8'(i);
    end
    @(negedge clk) wbuf_we = 1'b0;
  endtask

  task automatic run(string req, logic [3:0] k, logic [7:0] code, logic [15:0] w,
                     logic [CW-1:0] len, logic qb);
    int t;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_code = code; cmd_word = w;
    cmd_len = len; cmd_qbit = qb;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R13", "busy after accept", 32'(busy), 32'd1);
    t = 0;
    while (rsp_done !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    chk(req, "done reached", 32'(t < 3000), 32'd1);
    r_err = rsp_err; r_word = rsp_word; r_cnt = rsp_count;
    chk(req, "op count", 32'(nlog), 32'(nexp));
    for (int i = 0; i < nexp; i++)
      chk(req, $sformatf("op %0d", i), 32'(log_m[i]), 32'(exp_m[i]));
  endtask

  task automatic rb(int i, logic [7:0] expv, string req);
    @(negedge clk) rbuf_addr = AW'(i);
    @(negedge clk);
    chk(req, $sformatf("rbuf[%0d]", i), 32'(rbuf_data), 32'(expv));
  endtask

  task automatic t_quick();  // R3
    prep(); ex_s(); ex_w(8'h55); ex_p();
    run("R3", 4'd0, 8'h00, 16'h0, '0, 1'b1);
    chk("R3", "err", 32'(r_err), 0);
  endtask

  task automatic t_sendrecv();  // R4
    prep(); ex_s(); ex_w(8'h54); ex_w(8'h3C); ex_p();
    run("R4", 4'd1, 8'h77, 16'h003C, '0, 1'b0);
    prep(); rd_src[0] = 8'h9E; ex_s(); ex_w(8'h55); ex_r(1'b0); ex_p();
    run("R4", 4'd2, 8'h77, 16'h0, '0, 1'b0);
    chk("R4", "recv byte", 32'(r_word), 32'h009E);
  endtask

  task automatic t_writes();  // R5
    prep(); ex_s(); ex_w(8'h54); ex_w(8'h10); ex_w(8'hEF); ex_w(8'hBE); ex_p();
    run("R5", 4'd5, 8'h10, 16'hBEEF, '0, 1'b0);
    prep(); ex_s(); ex_w(8'h54); ex_w(8'h11); ex_w(8'h5A); ex_p();
    run("R5", 4'd3, 8'h11, 16'h125A, '0, 1'b0);
    chk("R5", "err", 32'(r_err), 0);
  endtask

  task automatic t_reads();  // R6
    prep(); rd_src[0] = 8'h34; rd_src[1] = 8'h12;
    ex_s(); ex_w(8'h54); ex_w(8'h22); ex_rs(); ex_w(8'h55); ex_r(1'b1); ex_r(1'b0); ex_p();
    run("R6", 4'd6, 8'h22, 16'h0, '0, 1'b0);
    chk("R6", "word", 32'(r_word), 32'h1234);
    prep(); rd_src[0] = 8'h6B;
    ex_s(); ex_w(8'h54); ex_w(8'h23); ex_rs(); ex_w(8'h55); ex_r(1'b0); ex_p();
    run("R6", 4'd4, 8'h23, 16'h0, '0, 1'b0);
    chk("R6", "byte", 32'(r_word), 32'h006B);
  endtask

  task automatic t_pcall();  // R7
    prep(); rd_src[0] = 8'hCD; rd_src[1] = 8'hAB;
    ex_s(); ex_w(8'h54); ex_w(8'h33); ex_w(8'h78); ex_w(8'h56);
    ex_rs(); ex_w(8'h55); ex_r(1'b1); ex_r(1'b0); ex_p();
    run("R7", 4'd7, 8'h33, 16'h5678, '0, 1'b0);
    chk("R7", "word", 32'(r_word), 32'hABCD);
  endtask

  task automatic t_blkwr();  // R8
    load_w(3, 8'h11);
    prep(); ex_s(); ex_w(8'h54); ex_w(8'h40); ex_w(8'h03);
    ex_w(8'h11); ex_w(8'h12); ex_w(8'h13); ex_p();
    run("R8", 4'd8, 8'h40, 16'h0, 6'd3, 1'b0);
    prep(); ex_s(); ex_w(8'h54); ex_w(8'h41); ex_w(8'h11); ex_w(8'h12); ex_p();
    run("R8", 4'd11, 8'h41, 16'h0, 6'd2, 1'b0);
  endtask

  task automatic t_blkrd();  // R9
    prep(); rd_src[0] = 8'h04;
    for (int i = 0; i < 4; i++) rd_src[i+1] = 8'hA0 + 8'(i);
    ex_s(); ex_w(8'h54); ex_w(8'h50); ex_rs(); ex_w(8'h55); ex_r(1'b1);
    ex_r(1'b1); ex_r(1'b1); ex_r(1'b1); ex_r(1'b0); ex_p();
    run("R9", 4'd9, 8'h50, 16'h0, '0, 1'b0);
    chk("R9", "count", 32'(r_cnt), 4);
    chk("R9", "err", 32'(r_err), 0);
    rb(0, 8'hA0, "R9"); rb(3, 8'hA3, "R9");
    prep(); for (int i = 0; i < 3; i++) rd_src[i] = 8'hC0 + 8'(i);
    ex_s(); ex_w(8'h54); ex_w(8'h51); ex_rs(); ex_w(8'h55); ex_r(1'b1); ex_r(1'b1); ex_r(1'b0); ex_p();
    run("R9", 4'd12, 8'h51, 16'h0, 6'd3, 1'b0);
    chk("R9", "raw count", 32'(r_cnt), 3);
    rb(2, 8'hC2, "R9");
  endtask

  task automatic t_badcount(logic [7:0] c);  // R10
    prep(); rd_src[0] = c; rd_src[1] = 8'hEE;
    ex_s(); ex_w(8'h54); ex_w(8'h50); ex_rs(); ex_w(8'h55); ex_r(1'b1); ex_r(1'b0); ex_p();
    run("R10", 4'd9, 8'h50, 16'h0, '0, 1'b0);
    chk("R10", "err", 32'(r_err), 1);
    chk("R10", "count", 32'(r_cnt), 0);
  endtask

  task automatic t_blkpcall();  // R11
    load_w(2, 8'h05);
    prep(); rd_src[0] = 8'd40;
    for (int i = 0; i < 40; i++) rd_src[i+1] = 8'h40 + 8'(i);
    ex_s(); ex_w(8'h54); ex_w(8'h60); ex_w(8'h02); ex_w(8'h05); ex_w(8'h06);
    ex_rs(); ex_w(8'h55); ex_r(1'b1);
    for (int i = 0; i < 32; i++) ex_r(i != 31);
    ex_p();
    run("R11", 4'd10, 8'h60, 16'h0, 6'd2, 1'b0);
    chk("R11", "count clamp", 32'(r_cnt), 32);
    chk("R11", "err", 32'(r_err), 0);
    rb(31, 8'h5F, "R11");
  endtask

  task automatic t_nack();  // R12
    prep(); nack_at = 1; ex_s(); ex_w(8'h54); ex_w(8'h19); ex_p();
    run("R12", 4'd3, 8'h19, 16'h0077, '0, 1'b0);
    chk("R12", "err code nack", 32'(r_err), 1);
    prep(); nack_at = 0; ex_s(); ex_w(8'h54); ex_p();
    run("R12", 4'd6, 8'h19, 16'h0, '0, 1'b0);
    chk("R12", "err addr nack", 32'(r_err), 1);
  endtask

  task automatic t_reject();  // R1
    prep();
    run("R1", 4'd8, 8'h40, 16'h0, 6'd0, 1'b0);
    chk("R1", "err len 0", 32'(r_err), 1);
    prep();
    run("R1", 4'd12, 8'h40, 16'h0, 6'd33, 1'b0);
    chk("R1", "err len 33", 32'(r_err), 1);
    prep();
    run("R1", 4'd14, 8'h40, 16'h0, 6'd1, 1'b0);
    chk("R1", "err bad kind", 32'(r_err), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13", "reset busy", 32'(busy), 0);
    chk("R13", "reset done", 32'(rsp_done), 0);
    chk("R13", "reset req", 32'(eng_req), 0);
    t_quick();
    t_sendrecv();
    t_writes();
    t_reads();
    t_pcall();
    t_blkwr();
    t_blkrd();
    t_badcount(8'h00);
    t_badcount(8'd40);
    t_blkpcall();
    t_nack();
    t_reject();
    chk("R2", "back-to-back requests", 32'(dbl_req), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    vec++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule